// File: doc/BRIEF.md
# Hardware Ticket Lock Unit

This block arbitrates one shared resource among a fixed set of requesters and hands it out strictly in arrival order. It keeps two counters: the number of the next ticket to give out and the number of the ticket now being served. A requester that raises its acquire strobe receives the current next-ticket value, and that counter advances, as one indivisible step. The requester then holds that ticket until the now-serving counter reaches it. At that point its grant goes high and it owns the resource.

The owner gives the resource back by pulsing its release strobe, and this moves the now-serving counter on by one. For each requester the block reports its ticket and whether it holds one. It also reports how many services remain ahead of it, which can drive a wait or backoff estimate. A release from a requester that is not the current owner changes nothing, but it produces a one-cycle error pulse.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset no requester holds a ticket, no grant is high, relError is low, and both counters are zero, so the first ticket issued is 0.
- R2: An acquire pulse from a requester that holds no ticket makes holdsTicket high on the next cycle. Its ticket equals the next-ticket counter, and that counter then advances by one.
- R3: Acquires raised in the same cycle get consecutive tickets, with the lowest requester index taking the lowest ticket.
- R4: granted[i] is high exactly when requester i holds a ticket equal to the now-serving counter, and at most one grant is high at a time.
- R5: A release from the granted requester advances the now-serving counter by one and clears that requester's holdsTicket on the next cycle.
- R6: Grants are given in the order the tickets were issued, which is first come, first served.
- R7: distance[i] equals (ticket minus now-serving) modulo 2^CNT_W for a requester holding a ticket, and it is 0 for a requester holding none.
- R8: A release from a requester that is not granted leaves every grant, ticket and distance unchanged. It raises relError for exactly the following cycle.
- R9: An acquire from a requester that already holds a ticket is ignored. Its ticket is unchanged, and the next ticket issued to anyone is unaffected.
- R10: Both counters wrap modulo 2^CNT_W, with CNT_W at least clog2(NUM_REQ)+1. Queue order and distances stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acqReq | input | NUM_REQ | Per-requester acquire strobe |
| relReq | input | NUM_REQ | Per-requester release strobe |
| ticketOut | output | NUM_REQ*CNT_W | Last ticket issued to each requester, CNT_W bits each, requester 0 in the low bits |
| holdsTicket | output | NUM_REQ | Requester holds an outstanding ticket (waiting or owning) |
| granted | output | NUM_REQ | Requester currently owns the resource |
| distance | output | NUM_REQ*CNT_W | Services remaining ahead of each requester, same packing as ticketOut |
| relError | output | 1 | Pulses for one cycle after a release from a non-owner |

## Verification
Tickets are first taken one at a time and then by three requesters in the same cycle. Comparing the two shows whether the consecutive numbering and the index priority of simultaneous arrivals are correct. Releases are then issued in queue order, interleaved with a stray release from a waiting requester and a repeated acquire from a holder. These patterns separate a correct advance of the serving counter from one that is corrupted by ignored inputs. A final round drives the counters through their wrap point with a queue that straddles it, which exposes any ordering or distance error caused by modulo arithmetic.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

  // Strobes from control to datapath that are common to all requesters
  typedef struct packed {
    logic advanceServe;  // now-serving counter moves on by one
    logic flagError;     // a stray release was seen this cycle
  } tluStrobes_t;

endpackage

// File: rtl/tlu_control.sv
module tlu_control
  import tlu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = 3
) (
  input  logic [NUM_REQ-1:0]            acqReq,
  input  logic [NUM_REQ-1:0]            relReq,
  input  logic [NUM_REQ-1:0]            holdVec,
  input  logic [NUM_REQ-1:0]            grantVec,
  output logic [NUM_REQ-1:0]            issueVec,
  output logic [NUM_REQ-1:0]            retireVec,
  output logic [NUM_REQ-1:0][CNT_W-1:0] issueOffset,
  output logic [CNT_W-1:0]              issueTotal,
  output tluStrobes_t                   strobes
);

  // Only requesters without a ticket may take one
  assign issueVec  = acqReq & ~holdVec;
  // Only the current owner may give the resource back
  assign retireVec = relReq & grantVec;

  // Prefix count: lower-index arrivals in the same cycle go first
  always_comb begin
    logic [CNT_W-1:0] runCount;
    runCount = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      issueOffset[i] = runCount;
      if (issueVec[i]) runCount = runCount + 1'b1;
    end
    issueTotal = runCount;
  end

  always_comb begin
    strobes.advanceServe = |retireVec;
    strobes.flagError    = |(relReq & ~grantVec);
  end

endmodule

// File: rtl/tlu_datapath.sv
module tlu_datapath
  import tlu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_REQ-1:0]            issueVec,
  input  logic [NUM_REQ-1:0]            retireVec,
  input  logic [NUM_REQ-1:0][CNT_W-1:0] issueOffset,
  input  logic [CNT_W-1:0]              issueTotal,
  input  tluStrobes_t                   strobes,
  output logic [NUM_REQ-1:0]            holdVec,
  output logic [NUM_REQ-1:0]            grantVec,
  output logic [NUM_REQ-1:0][CNT_W-1:0] ticketVec,
  output logic [NUM_REQ-1:0][CNT_W-1:0] distVec,
  output logic                          errPulse
);

  logic [CNT_W-1:0] nextTicket;
  logic [CNT_W-1:0] nowServing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nextTicket <= '0;
      nowServing <= '0;
      errPulse   <= 1'b0;
    end else begin
      nextTicket <= nextTicket + issueTotal;
      if (strobes.advanceServe) nowServing <= nowServing + 1'b1;
      errPulse <= strobes.flagError;
    end
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        holdVec[g]   <= 1'b0;
        ticketVec[g] <= '0;
      end else if (issueVec[g]) begin
        holdVec[g]   <= 1'b1;
        ticketVec[g] <= nextTicket + issueOffset[g];
      end else if (retireVec[g]) begin
        holdVec[g]   <= 1'b0;
      end
    end

    assign grantVec[g] = holdVec[g] && (ticketVec[g] == nowServing);
    assign distVec[g]  = holdVec[g] ? CNT_W'(ticketVec[g] - nowServing) : '0;
  end

endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
  import tlu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = $clog2(NUM_REQ) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REQ-1:0]         acqReq,
  input  logic [NUM_REQ-1:0]         relReq,
  output logic [NUM_REQ*CNT_W-1:0]   ticketOut,
  output logic [NUM_REQ-1:0]         holdsTicket,
  output logic [NUM_REQ-1:0]         granted,
  output logic [NUM_REQ*CNT_W-1:0]   distance,
  output logic                       relError
);

  logic [NUM_REQ-1:0]            issueVec;
  logic [NUM_REQ-1:0]            retireVec;
  logic [NUM_REQ-1:0][CNT_W-1:0] issueOffset;
  logic [CNT_W-1:0]              issueTotal;
  tluStrobes_t                   strobes;
  logic [NUM_REQ-1:0][CNT_W-1:0] ticketVec;
  logic [NUM_REQ-1:0][CNT_W-1:0] distVec;

  tlu_control #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) ctrl_i (
    .acqReq      (acqReq),
    .relReq      (relReq),
    .holdVec     (holdsTicket),
    .grantVec    (granted),
    .issueVec    (issueVec),
    .retireVec   (retireVec),
    .issueOffset (issueOffset),
    .issueTotal  (issueTotal),
    .strobes     (strobes)
  );

  tlu_datapath #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issueVec    (issueVec),
    .retireVec   (retireVec),
    .issueOffset (issueOffset),
    .issueTotal  (issueTotal),
    .strobes     (strobes),
    .holdVec     (holdsTicket),
    .grantVec    (granted),
    .ticketVec   (ticketVec),
    .distVec     (distVec),
    .errPulse    (relError)
  );

  assign ticketOut = ticketVec;
  assign distance  = distVec;

endmodule

// File: rtl/tlu_checker.sv
module tlu_checker #(
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_REQ-1:0]       acqReq,
  input logic [NUM_REQ-1:0]       relReq,
  input logic [NUM_REQ-1:0]       holdsTicket,
  input logic [NUM_REQ-1:0]       granted,
  input logic [NUM_REQ*CNT_W-1:0] distance,
  input logic                     relError
);

  assert_one_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(granted));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(relReq & ~granted)) |=> relError);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(relReq & ~granted)) |=> !relError);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acqReq[g] && !holdsTicket[g]) |=> holdsTicket[g]);

    assert_give_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (relReq[g] && granted[g]) |=> !holdsTicket[g]);

    assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      granted[g] |-> (holdsTicket[g] && distance[g*CNT_W +: CNT_W] == '0));

    assert_idle_dist_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !holdsTicket[g] |-> (distance[g*CNT_W +: CNT_W] == '0));
  end

endmodule

bind ticket_lock_unit tlu_checker #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .acqReq      (acqReq),
  .relReq      (relReq),
  .holdsTicket (holdsTicket),
  .granted     (granted),
  .distance    (distance),
  .relError    (relError)
);

// File: tb/ticket_lock_unit_tb_top.sv
module ticket_lock_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] acqReq = '0;
  logic [N-1:0] relReq = '0;
  logic [N*W-1:0] ticketOut;
  logic [N-1:0] holdsTicket;
  logic [N-1:0] granted;
  logic [N*W-1:0] distance;
  logic         relError;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ticket_lock_unit #(.NUM_REQ(N), .CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .acqReq(acqReq), .relReq(relReq),
    .ticketOut(ticketOut), .holdsTicket(holdsTicket), .granted(granted),
    .distance(distance), .relError(relError)
  );

  function automatic int tk(int i);
    return int'(ticketOut[i*W +: W]);
  endfunction

  function automatic int dst(int i);
    return int'(distance[i*W +: W]);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge: hold the strobes for one rising edge, return at the next negedge
  task automatic step(input logic [N-1:0] acq, input logic [N-1:0] rel);
    acqReq = acq;
    relReq = rel;
    @(negedge clk);
    acqReq = '0;
    relReq = '0;
  endtask

  task automatic test_reset();
    check("R1", "holdsTicket", int'(holdsTicket), 0);
    check("R1", "granted", int'(granted), 0);
    check("R1", "relError", int'(relError), 0);
  endtask

  task automatic test_single();
    step(4'b0001, 4'b0000);
    check("R2", "holds0", int'(holdsTicket[0]), 1);
    check("R1", "first ticket", tk(0), 0);
    check("R4", "granted", int'(granted), 4'b0001);
  endtask

  task automatic test_burst();
    step(4'b1110, 4'b0000);
    check("R3", "ticket1", tk(1), 1);
    check("R3", "ticket2", tk(2), 2);
    check("R3", "ticket3", tk(3), 3);
    check("R7", "dist1", dst(1), 1);
    check("R7", "dist3", dst(3), 3);
    check("R4", "granted", int'(granted), 4'b0001);
  endtask

  task automatic test_reacquire();
    step(4'b0100, 4'b0000);
    check("R9", "ticket2 kept", tk(2), 2);
    check("R9", "dist2 kept", dst(2), 2);
  endtask

  task automatic test_stray_release();
    step(4'b0000, 4'b1000);
    check("R8", "relError", int'(relError), 1);
    check("R8", "granted", int'(granted), 4'b0001);
    check("R8", "dist3", dst(3), 3);
    check("R8", "holds3", int'(holdsTicket[3]), 1);
    step(4'b0000, 4'b0000);
    check("R8", "relError one cycle", int'(relError), 0);
  endtask

  task automatic test_fifo_drain();
    step(4'b0000, 4'b0001);
    check("R5", "holds0 cleared", int'(holdsTicket[0]), 0);
    check("R6", "granted after 0", int'(granted), 4'b0010);
    check("R7", "dist2", dst(2), 1);
    check("R7", "dist0 idle", dst(0), 0);
    check("R8", "relError on valid release", int'(relError), 0);
    step(4'b0000, 4'b0010);
    check("R6", "granted after 1", int'(granted), 4'b0100);
    step(4'b0000, 4'b0100);
    check("R6", "granted after 2", int'(granted), 4'b1000);
    step(4'b0000, 4'b1000);
    check("R5", "all idle", int'(holdsTicket), 0);
    check("R4", "no grant", int'(granted), 0);
  endtask

  task automatic test_wrap();
    // Counters now at 4; three solo rounds bring them to 7
    for (int k = 0; k < 3; k++) begin
      step(4'b0001, 4'b0000);
      check("R10", "solo ticket", tk(0), 4 + k);
      check("R4", "solo grant", int'(granted[0]), 1);
      step(4'b0000, 4'b0001);
    end
    step(4'b1110, 4'b0000);
    check("R10", "ticket1 before wrap", tk(1), 7);
    check("R10", "ticket2 wrapped", tk(2), 0);
    check("R10", "ticket3 wrapped", tk(3), 1);
    check("R10", "dist3 across wrap", dst(3), 2);
    check("R4", "grant at 7", int'(granted), 4'b0010);
    step(4'b0000, 4'b0010);
    check("R10", "grant at 0", int'(granted), 4'b0100);
    check("R10", "dist3", dst(3), 1);
    step(4'b0000, 4'b0100);
    check("R10", "grant at 1", int'(granted), 4'b1000);
    step(4'b0000, 4'b1000);
    check("R10", "idle after wrap", int'(holdsTicket), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_single();
    test_burst();
    test_reacquire();
    test_stray_release();
    test_fifo_drain();
    test_wrap();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule